// File: doc/BRIEF.md
# Serial Command Threshold Controller

This block listens on an asynchronous serial receive line, gathers the incoming ASCII characters into text lines and turns a small set of two-character commands into adjustments of two 8-bit tuning values. One value is a binarization coefficient and the other is a secondary threshold. Both are presented continuously on output ports for downstream image logic. Every byte that arrives intact is sent back unchanged on the serial transmit line, so a terminal shows what was typed.

A line ends with a carriage return immediately followed by a line feed. A complete line of exactly two characters may be a command that steps one of the two values by a fixed amount. An empty line raises a help-request pulse. The "3s" line raises a show-request pulse. Any other complete line raises an error pulse. Text responses are produced by other logic that watches these pulses.

The serial timing comes from a divider of the system clock. It runs at 16 ticks per bit, and the parameters are set for 115200 baud by default.

Top module: `serial_tune_ctrl`

## Requirements
- R1: Receive frames are 8N1: a low start bit, 8 data bits sent LSB first, then a high stop bit. Each bit lasts 16 oversampling ticks. A frame whose stop bit reads low is dropped, and it is neither echoed nor given to the line assembler.
- R2: Every correctly framed received byte is transmitted back unchanged in 8N1 format, whatever the line-assembly state.
- R3: After reset the coefficient output is 128, the secondary output is 8, all three pulse outputs are low and the transmit line is high.
- R4: The line "1y" (0x31 0x79) adds 5 to the coefficient and "1n" (0x31 0x6E) subtracts 5. The arithmetic is modulo 256 with no saturation.
- R5: The line "2y" (0x32 0x79) adds 1 to the secondary value and "2n" (0x32 0x6E) subtracts 1. The arithmetic is modulo 256.
- R6: A line is complete when 0x0D is received and the next received byte is 0x0A. If the byte after 0x0D is anything else, that byte and the partial line are discarded and assembly starts again from an empty line.
- R7: A line holds at most 128 payload bytes. A payload byte that arrives when 128 are already held is discarded, and the count returns to zero.
- R8: When a line completes, exactly one one-cycle pulse follows on the next clock: help for an empty line, show for "3s" (0x33 0x73), and error for any line that is not one of the five recognised lines.
- R9: The two value outputs change only on the clock edge that follows completion of a stepping command. Lines of any other length or content leave both values unchanged.
- R10: Lines sent back to back with no idle time between frames are all decoded, and after each completed line assembly restarts with an empty line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_rx | input | 1 | Asynchronous serial receive line, idle high |
| serial_tx | output | 1 | Serial transmit line carrying the echo, idle high |
| coef_q | output | 8 | Binarization coefficient value |
| aux_q | output | 8 | Secondary threshold value |
| help_pulse | output | 1 | One-cycle pulse on an empty line |
| show_pulse | output | 1 | One-cycle pulse on the line "3s" |
| err_pulse | output | 1 | One-cycle pulse on an unrecognised line |

## Verification
The assertions check, on every cycle, that the pulses are mutually exclusive and last one cycle, that the line count stays within its bound, that each stepping command moves exactly the right register by its step with wraparound, and that no other decode outcome disturbs either register. The framing rules can only be shown by the bench's scenarios: the abort after a stray byte following a carriage return, the overflow reset at 128 bytes, the dropping of low-stop frames, and the byte-for-byte echo. The bench also sweeps both registers through their wrap points, checking each step.

// File: rtl/stc_pkg.sv
// Shared types and character codes for the serial command threshold controller.
package stc_pkg;

    // Receiver framing states
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_t;

    // Line assembler states
    typedef enum logic {
        ASM_COLLECT,
        ASM_WAIT_LF
    } asm_state_t;

    // Outcome of a completed line; CMD_NONE when no line completes this cycle
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_COEF_UP,
        CMD_COEF_DN,
        CMD_AUX_UP,
        CMD_AUX_DN,
        CMD_HELP,
        CMD_SHOW,
        CMD_ERR
    } cmd_t;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_1  = 8'h31;
    localparam logic [7:0] CH_2  = 8'h32;
    localparam logic [7:0] CH_3  = 8'h33;
    localparam logic [7:0] CH_Y  = 8'h79;
    localparam logic [7:0] CH_N  = 8'h6E;
    localparam logic [7:0] CH_S  = 8'h73;

endpackage

// File: rtl/uart_rx_os.sv
// Oversampling 8N1 receiver.
// Assumes: tick pulses at OS times the baud rate; the line idles high.
// A byte is reported with a one-cycle valid pulse at the middle of its stop bit.
// A frame with a low stop bit is dropped, and the receiver then waits for the line to go high again.
module uart_rx_os #(
    parameter int OS     = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    import stc_pkg::*;

    localparam int CW  = $clog2(OS);
    localparam int BW  = $clog2(DATA_W);
    localparam logic [CW-1:0] HALF = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);
    localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

    logic              s0, s1;
    rx_state_t         state;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;

    // Two-flop synchronizer for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0 <= 1'b1;
            s1 <= 1'b1;
        end else begin
            s0 <= rxd;
            s1 <= s0;
        end
    end

    // Framing state machine: start check, data shift, stop check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (tick && !s1) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == HALF) begin
                            tcnt <= '0;
                            bitn <= '0;
                            state <= s1 ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == LAST) begin
                            tcnt  <= '0;
                            shreg <= {s1, shreg[DATA_W-1:1]};
                            if (bitn == BLAST) state <= RX_STOP;
                            else               bitn  <= bitn + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == LAST) begin
                            tcnt <= '0;
                            if (s1) begin
                                valid <= 1'b1;
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_WAIT_HIGH;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_WAIT_HIGH: begin
                    if (s1) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign data = shreg;

endmodule

// File: rtl/uart_tx_os.sv
// 8N1 transmitter timed by the same oversampling tick as the receiver.
// Assumes: load is only honoured while busy is low; the line idles high.
module uart_tx_os #(
    parameter int OS     = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CW      = $clog2(OS);
    localparam int NW      = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      tcnt;
    logic [NW-1:0]      left;

    // Load a frame, then shift one bit out every OS ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            tcnt  <= '0;
            left  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                shreg <= {1'b1, data, 1'b0};
                tcnt  <= '0;
                left  <= NW'(FRAME_W);
                busy  <= 1'b1;
            end
        end else if (tick) begin
            if (tcnt == LAST) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - 1'b1;
                if (left == NW'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/line_cmd_decoder.sv
// Line assembler and command classifier.
// Assumes: byte_valid is a one-cycle strobe, and two strobes are never adjacent.
// Only the first two payload bytes are kept, because longer lines are never commands.
// cmd is combinational and valid in the cycle the terminating line feed is presented.
module line_cmd_decoder #(
    parameter int LINE_MAX = 128,
    parameter int CNT_W    = $clog2(LINE_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    output stc_pkg::cmd_t       cmd,
    output logic [CNT_W-1:0]    line_cnt,
    output stc_pkg::asm_state_t asm_state
);
    import stc_pkg::*;

    logic [7:0] first_q, second_q;

    // Classify the line when a line feed follows the carriage return
    always_comb begin
        cmd = CMD_NONE;
        if (byte_valid && asm_state == ASM_WAIT_LF && byte_data == CH_LF) begin
            if (line_cnt == '0) begin
                cmd = CMD_HELP;
            end else if (line_cnt == CNT_W'(2)) begin
                case ({first_q, second_q})
                    {CH_1, CH_Y}: cmd = CMD_COEF_UP;
                    {CH_1, CH_N}: cmd = CMD_COEF_DN;
                    {CH_2, CH_Y}: cmd = CMD_AUX_UP;
                    {CH_2, CH_N}: cmd = CMD_AUX_DN;
                    {CH_3, CH_S}: cmd = CMD_SHOW;
                    default:      cmd = CMD_ERR;
                endcase
            end else begin
                cmd = CMD_ERR;
            end
        end
    end

    // Track the assembler state, the payload count and the first two bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_state <= ASM_COLLECT;
            line_cnt  <= '0;
            first_q   <= '0;
            second_q  <= '0;
        end else if (byte_valid) begin
            case (asm_state)
                ASM_COLLECT: begin
                    if (byte_data == CH_CR) begin
                        asm_state <= ASM_WAIT_LF;
                    end else if (line_cnt == CNT_W'(LINE_MAX)) begin
                        line_cnt <= '0;
                    end else begin
                        if (line_cnt == CNT_W'(0)) first_q  <= byte_data;
                        if (line_cnt == CNT_W'(1)) second_q <= byte_data;
                        line_cnt <= line_cnt + 1'b1;
                    end
                end
                ASM_WAIT_LF: begin
                    asm_state <= ASM_COLLECT;
                    line_cnt  <= '0;
                end
                default: asm_state <= ASM_COLLECT;
            endcase
        end
    end

endmodule

// File: rtl/serial_tune_ctrl.sv
// Top: serial command threshold controller.
// Receives serial text, echoes each good byte, assembles lines and applies
// step commands to two tuning registers. It also pulses the help, show and error outputs.
// Assumes: CLK_HZ is at least OS times BAUD; rst_n is synchronous and active low.
module serial_tune_ctrl #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int BAUD      = 115_200,
    parameter int OS        = 16,
    parameter int LINE_MAX  = 128,
    parameter int VAL_W     = 8,
    parameter int COEF_INIT = 128,
    parameter int AUX_INIT  = 8,
    parameter int COEF_STEP = 5,
    parameter int AUX_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_rx,
    output logic             serial_tx,
    output logic [VAL_W-1:0] coef_q,
    output logic [VAL_W-1:0] aux_q,
    output logic             help_pulse,
    output logic             show_pulse,
    output logic             err_pulse
);
    import stc_pkg::*;

    localparam int TICK_DIV = (CLK_HZ / (BAUD * OS)) < 1 ? 1 : CLK_HZ / (BAUD * OS);
    localparam int CNT_W    = $clog2(LINE_MAX + 1);

    logic             tick;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             tx_busy;
    logic             tx_load;
    logic             pend_full;
    logic [7:0]       pend_data;
    cmd_t             cmd;
    logic [CNT_W-1:0] line_cnt;
    asm_state_t       asm_state;

    // Oversampling tick: constant when the clock already matches OS x baud
    generate
        if (TICK_DIV == 1) begin : g_tick_direct
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q;
            // Divide the clock down to one tick every TICK_DIV cycles
            always_ff @(posedge clk) begin
                if (!rst_n || div_q == DW'(TICK_DIV - 1)) div_q <= '0;
                else                                     div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DW'(TICK_DIV - 1));
        end
    endgenerate

    uart_rx_os #(.OS(OS), .DATA_W(8)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (serial_rx),
        .valid (rx_valid),
        .data  (rx_data)
    );

    assign tx_load = pend_full && !tx_busy;

    // One-entry holding register that absorbs phase skew between receive and echo
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_data <= '0;
        end else if (rx_valid) begin
            pend_full <= 1'b1;
            pend_data <= rx_data;
        end else if (tx_load) begin
            pend_full <= 1'b0;
        end
    end

    uart_tx_os #(.OS(OS), .DATA_W(8)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tx_load),
        .data  (pend_data),
        .busy  (tx_busy),
        .txd   (serial_tx)
    );

    line_cmd_decoder #(.LINE_MAX(LINE_MAX), .CNT_W(CNT_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_valid),
        .byte_data  (rx_data),
        .cmd        (cmd),
        .line_cnt   (line_cnt),
        .asm_state  (asm_state)
    );

    // Tuning registers: step only on a recognised stepping command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= VAL_W'(COEF_INIT);
            aux_q  <= VAL_W'(AUX_INIT);
        end else begin
            case (cmd)
                CMD_COEF_UP: coef_q <= coef_q + VAL_W'(COEF_STEP);
                CMD_COEF_DN: coef_q <= coef_q - VAL_W'(COEF_STEP);
                CMD_AUX_UP:  aux_q  <= aux_q + VAL_W'(AUX_STEP);
                CMD_AUX_DN:  aux_q  <= aux_q - VAL_W'(AUX_STEP);
                default: ;
            endcase
        end
    end

    // Request pulses, one cycle each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            help_pulse <= 1'b0;
            show_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            help_pulse <= (cmd == CMD_HELP);
            show_pulse <= (cmd == CMD_SHOW);
            err_pulse  <= (cmd == CMD_ERR);
        end
    end

endmodule

// File: rtl/stc_checker.sv
// Protocol checker bound to serial_tune_ctrl; observes decoder outcome, count and outputs.
module stc_checker #(
    parameter int LINE_MAX  = 128,
    parameter int VAL_W     = 8,
    parameter int COEF_STEP = 5,
    parameter int AUX_STEP  = 1,
    parameter int CNT_W     = $clog2(LINE_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input stc_pkg::cmd_t    cmd,
    input logic [CNT_W-1:0] line_cnt,
    input logic [VAL_W-1:0] coef_q,
    input logic [VAL_W-1:0] aux_q,
    input logic             help_pulse,
    input logic             show_pulse,
    input logic             err_pulse
);
    import stc_pkg::*;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({help_pulse, show_pulse, err_pulse})); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (help_pulse || show_pulse || err_pulse) |=> !(help_pulse || show_pulse || err_pulse)); // R8

    AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ERR) |=> err_pulse); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= CNT_W'(LINE_MAX)); // R7

    AST_COEF_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_COEF_UP) |=> (coef_q == VAL_W'($past(coef_q) + VAL_W'(COEF_STEP)))); // R4

    AST_COEF_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_COEF_DN) |=> (coef_q == VAL_W'($past(coef_q) - VAL_W'(COEF_STEP)))); // R4

    AST_AUX_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AUX_UP) |=> (aux_q == VAL_W'($past(aux_q) + VAL_W'(AUX_STEP)))); // R5

    AST_AUX_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AUX_DN) |=> (aux_q == VAL_W'($past(aux_q) - VAL_W'(AUX_STEP)))); // R5

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE || cmd == CMD_HELP || cmd == CMD_SHOW || cmd == CMD_ERR)
        |=> ($stable(coef_q) && $stable(aux_q))); // R9

endmodule

bind serial_tune_ctrl stc_checker #(
    .LINE_MAX  (LINE_MAX),
    .VAL_W     (VAL_W),
    .COEF_STEP (COEF_STEP),
    .AUX_STEP  (AUX_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .line_cnt   (line_cnt),
    .coef_q     (coef_q),
    .aux_q      (aux_q),
    .help_pulse (help_pulse),
    .show_pulse (show_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/serial_tune_ctrl_tb.sv
// Bench: the clock-to-baud ratio is set so that one tick equals one clock (16 clocks per bit).
module serial_tune_ctrl_tb;

    localparam int BIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] coef, aux;
    logic       help_p, show_p, err_p;

    int checks = 0, fails = 0;
    int help_n = 0, show_n = 0, err_n = 0;
    int exp_help = 0, exp_show = 0, exp_err = 0;
    logic [7:0] exp_coef = 8'd128, exp_aux = 8'd8;
    logic [7:0] echo_exp[$];
    logic [7:0] echo_got[$];

    always #2.5 clk = ~clk;

    serial_tune_ctrl #(.CLK_HZ(1_843_200), .BAUD(115_200)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .serial_rx  (rxd),
        .serial_tx  (txd),
        .coef_q     (coef),
        .aux_q      (aux),
        .help_pulse (help_p),
        .show_pulse (show_p),
        .err_pulse  (err_p)
    );

    // Count pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (help_p) help_n++;
            if (show_p) show_n++;
            if (err_p)  err_n++;
        end
    end

    // Decode the echo line into a list of bytes
    initial begin
        logic [7:0] b;
        wait (rst_n);
        forever begin
            @(negedge txd);
            repeat (BIT / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (BIT) @(negedge clk);
                b[i] = txd;
            end
            repeat (BIT) @(negedge clk);
            echo_got.push_back(b);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop = 1'b1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = good_stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        if (good_stop) echo_exp.push_back(b);
    endtask

    task automatic send_text(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    // Send a line with CR LF and update the expected model
    task automatic send_line(input string s);
        send_text(s);
        send_byte(8'h0D);
        send_byte(8'h0A);
        if (s.len() == 0)      exp_help++;
        else if (s == "1y")    exp_coef = exp_coef + 8'd5;
        else if (s == "1n")    exp_coef = exp_coef - 8'd5;
        else if (s == "2y")    exp_aux  = exp_aux + 8'd1;
        else if (s == "2n")    exp_aux  = exp_aux - 8'd1;
        else if (s == "3s")    exp_show++;
        else                   exp_err++;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_state(input string req);
        check(coef == exp_coef, {req, " coef"}, coef, exp_coef);
        check(aux == exp_aux, {req, " aux"}, aux, exp_aux);
        check(help_n == exp_help, {req, " help count"}, help_n, exp_help);
        check(show_n == exp_show, {req, " show count"}, show_n, exp_show);
        check(err_n == exp_err, {req, " err count"}, err_n, exp_err);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check(coef == 8'd128, "R3 coef reset", coef, 128);
        check(aux == 8'd8, "R3 aux reset", aux, 8);
        check({help_p, show_p, err_p} == 3'b000, "R3 pulses low", {help_p, show_p, err_p}, 0);
        check(txd == 1'b1, "R3 tx idle", txd, 1);

        // R4 sweep the coefficient down through the wrap point
        for (int i = 0; i < 27; i++) begin
            send_line("1n");
            check_state("R4 1n sweep");
        end
        for (int i = 0; i < 3; i++) begin
            send_line("1y");
            check_state("R4 1y");
        end
        // R5 secondary down through zero, then up across it
        for (int i = 0; i < 10; i++) begin
            send_line("2n");
            check_state("R5 2n sweep");
        end
        for (int i = 0; i < 3; i++) begin
            send_line("2y");
            check_state("R5 2y");
        end

        // R8 help, show, error
        send_line("");
        check_state("R8 empty line");
        send_line("3s");
        check_state("R8 show");
        send_line("1x");
        check_state("R8 unknown pair");
        // R9 wrong lengths leave the registers alone
        send_line("1yy");
        check_state("R9 three bytes");
        send_line("1");
        check_state("R9 one byte");
        send_line("y1");
        check_state("R9 swapped pair");

        // R6 stray byte after CR aborts the line
        send_text("zz");
        send_byte(8'h0D);
        send_byte(8'h51);
        send_line("1y");
        check_state("R6 abort then command");

        // R7 a full 128-byte line completes as an error
        for (int i = 0; i < 128; i++) send_byte(8'h61);
        send_line("");
        exp_help--;
        exp_err++;
        check_state("R7 full line");
        // R7 the 129th byte clears the count
        for (int i = 0; i < 129; i++) send_byte(8'h61);
        send_line("2y");
        check_state("R7 overflow restart");

        // R1 a low-stop frame is dropped
        send_byte(8'h31);
        send_byte(8'h79, 1'b0);
        repeat (2 * BIT) @(negedge clk);
        send_line("y");
        exp_err--;
        exp_coef = exp_coef + 8'd5;
        check_state("R1 bad stop dropped");

        // R10 back-to-back lines
        send_text("2y");
        send_byte(8'h0D);
        send_byte(8'h0A);
        send_line("2y");
        exp_aux = exp_aux + 8'd1;
        check_state("R10 back to back");

        // R2 echo contents
        repeat (30 * BIT) @(negedge clk);
        check(echo_got.size() == echo_exp.size(), "R2 echo count", echo_got.size(), echo_exp.size());
        for (int i = 0; i < echo_exp.size() && i < echo_got.size(); i++)
            check(echo_got[i] == echo_exp[i], "R2 echo byte", echo_got[i], echo_exp[i]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190_000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule